// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the programmable feedback divider of a frequency synthesizer loop. It runs on the output clock of an external dual-modulus prescaler, and its modulus-select output steers that prescaler. Two counts work together. A swallow count A (6 bits) keeps the prescaler dividing by P+1 for the first A prescaler periods of every output period. A main count B (13 bits) sets the total length of the output period to B prescaler periods, so the last B−A of them run at P. Referred to the RF input, each output period is therefore A·(P+1) + (B−A)·P = B·P + A cycles long. At the end of each period the block emits a single-cycle pulse toward the phase detector.

Software-facing values A, B and a two-bit base-modulus code arrive on a load strobe. A legal set is held as pending and becomes active only at the next period boundary, so a period already under way is never cut short or stretched. An illegal set (B below A, or B below 3) raises an error flag and is otherwise discarded. The active modulus code is passed on to the prescaler with the same boundary timing.

The sequencer has three states. IDLE is the state after reset: no pulses and modulus-select low. START (IDLE → SWAL or IDLE → MAIN) happens on the first edge at which a pending legal set exists. SWAL drives modulus-select high. SWAL → MAIN happens when the position count reaches A. Both running states take the WRAP transition on the edge after the last position B−1: both counts restart, pending values are applied, and the state becomes SWAL if the new A is non-zero and MAIN otherwise.

Top module: `pswl_div`

## Requirements
- R1: After reset, modsel_o, fbk_pulse_o and cfg_err_o are 0, and no pulse appears until a legal set has been loaded.
- R2: With B active, each output period lasts exactly B prescaler-clock cycles, and fbk_pulse_o is high only in the last cycle of the period, for one cycle.
- R3: Within each period, modsel_o is high in the first A cycles and low in the remaining B−A cycles. When A = 0 it is never high.
- R4: The RF cycles per period, computed as (cycles with modsel_o high)·(P+1) + (cycles with it low)·P, equal B·P + A for every code on psel_i (00 → P=8, 01 → 16, 10 → 32, 11 → 64). psel_o shows the code of the active set.
- R5: A set is legal when 3 ≤ B and A ≤ B. A load with an illegal set drives cfg_err_o high from the next cycle and leaves the divider's behaviour unchanged. The next legal load clears cfg_err_o.
- R6: A legal set loaded while running takes effect at the first period boundary after the edge that captures it, including when the load is captured on a boundary edge itself. The period in progress keeps its length and modulus pattern. From IDLE, the first legal set starts position 0 on the next edge.
- R7: When A = B, modsel_o stays high for the whole period.
- R8: Without new loads, consecutive periods repeat the same length and modulus pattern; both counts reload at every boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pre | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Active-low reset |
| load_i | input | 1 | Load strobe for swal_i, main_i, psel_i |
| swal_i | input | 6 | Programmed swallow count A |
| main_i | input | 13 | Programmed main count B |
| psel_i | input | 2 | Programmed base-modulus code |
| modsel_o | output | 1 | 1: prescaler divides by P+1; 0: by P |
| fbk_pulse_o | output | 1 | One-cycle pulse at the end of each period |
| psel_o | output | 2 | Base-modulus code of the active set |
| cfg_err_o | output | 1 | Last load was illegal |

## Verification
The sequencer assertions assume that the active set is always legal, in particular that B is at least 3, so that a pulse can never repeat on consecutive cycles and the position never reaches B. The input filter guarantees this whatever is driven on the ports. The stimulus changes inputs only on falling edges, and it offers illegal sets only in directed cases that check the error flag and confirm that the running pattern is kept. Every measured period is taken at least one full boundary after the load, so each expected value belongs to a single active set.

// File: rtl/pswl_pkg.sv
package pswl_pkg;
    localparam int A_W_DEF   = 6;
    localparam int B_W_DEF   = 13;
    localparam int P_W_DEF   = 2;
    localparam int B_MIN_DEF = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SWAL = 2'd1,
        ST_MAIN = 2'd2
    } pswl_st_e;
endpackage

// File: rtl/pswl_cfg.sv
module pswl_cfg
    import pswl_pkg::*;
#(
    parameter int AW   = A_W_DEF,
    parameter int BW   = B_W_DEF,
    parameter int PW   = P_W_DEF,
    parameter int BMIN = B_MIN_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [AW-1:0] a_in,
    input  logic [BW-1:0] b_in,
    input  logic [PW-1:0] p_in,
    input  logic          take,
    output logic          pend_vld,
    output logic [AW-1:0] pend_a,
    output logic [BW-1:0] pend_b,
    output logic [PW-1:0] pend_p,
    output logic          err
);
    logic legal;

    always_comb begin
        legal = (b_in >= BW'(BMIN)) && (b_in >= BW'(a_in));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_vld <= 1'b0;
            pend_a   <= '0;
            pend_b   <= '0;
            pend_p   <= '0;
            err      <= 1'b0;
        end else begin
            if (take) begin
                pend_vld <= 1'b0;
            end
            if (ld) begin
                if (legal) begin
                    pend_a   <= a_in;
                    pend_b   <= b_in;
                    pend_p   <= p_in;
                    pend_vld <= 1'b1;
                    err      <= 1'b0;
                end else begin
                    err <= 1'b1;
                end
            end
        end
    end

    AST_ILLEGAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !legal) |=> ($stable(pend_a) && $stable(pend_b) && $stable(pend_p))); // R5
    AST_LEGAL_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && legal) |=> pend_vld); // R6
endmodule

// File: rtl/pswl_seq.sv
module pswl_seq
    import pswl_pkg::*;
#(
    parameter int AW = A_W_DEF,
    parameter int BW = B_W_DEF,
    parameter int PW = P_W_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pend_vld,
    input  logic [AW-1:0] pend_a,
    input  logic [BW-1:0] pend_b,
    input  logic [PW-1:0] pend_p,
    output logic          take,
    output logic          mod_ctl,
    output logic          div_pulse,
    output logic [PW-1:0] p_act
);
    pswl_st_e      st_q, st_d;
    logic [BW-1:0] pos_q, pos_d;
    logic [BW-1:0] b_q, b_d;
    logic [AW-1:0] a_q, a_d;
    logic [PW-1:0] p_q, p_d;
    logic          running, last, boundary;

    always_comb begin
        running  = (st_q != ST_IDLE);
        last     = running && (pos_q == (b_q - BW'(1)));
        boundary = last || (!running && pend_vld);
    end

    // next-state logic
    always_comb begin
        st_d  = st_q;
        pos_d = pos_q;
        a_d   = a_q;
        b_d   = b_q;
        p_d   = p_q;
        if (boundary) begin
            if (pend_vld) begin
                a_d = pend_a;
                b_d = pend_b;
                p_d = pend_p;
            end
            pos_d = '0;
            st_d  = (a_d != '0) ? ST_SWAL : ST_MAIN;
        end else begin
            unique case (st_q)
                ST_IDLE: st_d = ST_IDLE;
                ST_SWAL: begin
                    pos_d = pos_q + 1'b1;
                    if (pos_d == BW'(a_q)) begin
                        st_d = ST_MAIN;
                    end
                end
                ST_MAIN: pos_d = pos_q + 1'b1;
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            pos_q <= '0;
            a_q   <= '0;
            b_q   <= '0;
            p_q   <= '0;
        end else begin
            st_q  <= st_d;
            pos_q <= pos_d;
            a_q   <= a_d;
            b_q   <= b_d;
            p_q   <= p_d;
        end
    end

    // outputs
    always_comb begin
        mod_ctl   = (st_q == ST_SWAL);
        div_pulse = last;
        take      = boundary && pend_vld;
        p_act     = p_q;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (pos_q < b_q)); // R2
    AST_PULSE_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse); // R2
    AST_MOD_RISE_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_ctl) |-> (pos_q == '0)); // R3
    AST_MOD_FALL_AT_A: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mod_ctl) |-> (pos_q == BW'(a_q))); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> (!mod_ctl && !div_pulse)); // R1
endmodule

// File: rtl/pswl_div.sv
module pswl_div
    import pswl_pkg::*;
#(
    parameter int AW   = A_W_DEF,
    parameter int BW   = B_W_DEF,
    parameter int PW   = P_W_DEF,
    parameter int BMIN = B_MIN_DEF
) (
    input  logic          clk_pre,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] swal_i,
    input  logic [BW-1:0] main_i,
    input  logic [PW-1:0] psel_i,
    output logic          modsel_o,
    output logic          fbk_pulse_o,
    output logic [PW-1:0] psel_o,
    output logic          cfg_err_o
);
    logic          pend_vld, take;
    logic [AW-1:0] pend_a;
    logic [BW-1:0] pend_b;
    logic [PW-1:0] pend_p;

    pswl_cfg #(.AW(AW), .BW(BW), .PW(PW), .BMIN(BMIN)) u_cfg (
        .clk      (clk_pre),
        .rst_n    (rst_n),
        .ld       (load_i),
        .a_in     (swal_i),
        .b_in     (main_i),
        .p_in     (psel_i),
        .take     (take),
        .pend_vld (pend_vld),
        .pend_a   (pend_a),
        .pend_b   (pend_b),
        .pend_p   (pend_p),
        .err      (cfg_err_o)
    );

    pswl_seq #(.AW(AW), .BW(BW), .PW(PW)) u_seq (
        .clk       (clk_pre),
        .rst_n     (rst_n),
        .pend_vld  (pend_vld),
        .pend_a    (pend_a),
        .pend_b    (pend_b),
        .pend_p    (pend_p),
        .take      (take),
        .mod_ctl   (modsel_o),
        .div_pulse (fbk_pulse_o),
        .p_act     (psel_o)
    );

    AST_ERR_FLAG: assert property (@(posedge clk_pre) disable iff (!rst_n)
        (load_i && ((main_i < BW'(swal_i)) || (main_i < BW'(BMIN)))) |=> cfg_err_o); // R5
endmodule

// File: tb/sim_pswl_div.sv
module sim_pswl_div;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld = 1'b0;
    logic [5:0]  a_i = '0;
    logic [12:0] b_i = '0;
    logic [1:0]  p_i = '0;
    logic        mod_o, pls_o, err_o;
    logic [1:0]  psel_o;

    int checks = 0;
    int errors = 0;

    pswl_div u0 (
        .clk_pre     (clk),
        .rst_n       (rst_n),
        .load_i      (ld),
        .swal_i      (a_i),
        .main_i      (b_i),
        .psel_i      (p_i),
        .modsel_o    (mod_o),
        .fbk_pulse_o (pls_o),
        .psel_o      (psel_o),
        .cfg_err_o   (err_o)
    );

    always #10 clk = ~clk;

    // {A[5:0], B[12:0], Pcode[1:0]}
    localparam logic [20:0] VEC [0:5] = '{
        {6'd0,  13'd3,    2'd0},
        {6'd3,  13'd10,   2'd1},
        {6'd63, 13'd63,   2'd2},
        {6'd5,  13'd40,   2'd3},
        {6'd63, 13'd8191, 2'd1},
        {6'd17, 13'd100,  2'd0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic load(input int a, input int b, input int p);
        @(negedge clk);
        ld  = 1'b1;
        a_i = 6'(a);
        b_i = 13'(b);
        p_i = 2'(p);
        @(negedge clk);
        ld = 1'b0;
    endtask

    task automatic wait_pulse();
        do @(negedge clk); while (!pls_o);
    endtask

    task automatic meas_now(output int len, output int hi, output int ord);
        bit seen_low;
        len = 0; hi = 0; ord = 1; seen_low = 0;
        do begin
            @(negedge clk);
            ld = 1'b0;
            len++;
            if (mod_o) begin
                hi++;
                if (seen_low) ord = 0;
            end else begin
                seen_low = 1;
            end
        end while (!pls_o);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int len, hi, ord, len2, hi2, ord2, pulses, mods;
        repeat (5) @(negedge clk);
        chk("R1 modsel in reset", int'(mod_o), 0);
        chk("R1 pulse in reset", int'(pls_o), 0);
        chk("R1 err in reset", int'(err_o), 0);
        rst_n = 1'b1;
        pulses = 0; mods = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            pulses += int'(pls_o);
            mods   += int'(mod_o);
        end
        chk("R1 no pulse before load", pulses, 0);
        chk("R1 no modsel before load", mods, 0);

        // R6: start from idle, first period is B long
        load(0, 3, 0);
        meas_now(len, hi, ord);
        chk("R6 first period from idle", len, 3);

        foreach (VEC[k]) begin
            int a, b, p, pv;
            a  = int'(VEC[k][20:15]);
            b  = int'(VEC[k][14:2]);
            p  = int'(VEC[k][1:0]);
            pv = 8 << p;
            load(a, b, p);
            wait_pulse();
            wait_pulse();
            meas_now(len, hi, ord);
            chk("R2 period length", len, b);
            chk("R3 modsel high count", hi, a);
            chk("R3 modsel high first", ord, 1);
            chk("R4 RF cycles per period", hi * (pv + 1) + (len - hi) * pv, b * pv + a);
            chk("R4 active modulus code", int'(psel_o), p);
            if (a == b) chk("R7 modsel whole period", hi, len);
            meas_now(len2, hi2, ord2);
            chk("R8 repeat length", len2, len);
            chk("R8 repeat pattern", hi2, hi);
        end

        // R5: B below A rejected
        load(40, 20, 3);
        chk("R5 err after B<A", int'(err_o), 1);
        wait_pulse();
        meas_now(len, hi, ord);
        chk("R5 B<A ignored length", len, 100);
        chk("R5 B<A ignored pattern", hi, 17);
        chk("R5 B<A ignored code", int'(psel_o), 0);

        // R5: B below 3 rejected
        load(0, 2, 1);
        chk("R5 err after B<3", int'(err_o), 1);
        wait_pulse();
        meas_now(len, hi, ord);
        chk("R5 B<3 ignored length", len, 100);

        // R5: legal load clears flag
        load(2, 5, 0);
        chk("R5 err cleared", int'(err_o), 0);
        wait_pulse();
        wait_pulse();
        meas_now(len, hi, ord);
        chk("R2 short period", len, 5);

        // R6: load captured on a boundary edge applies one period later
        wait_pulse();
        ld  = 1'b1;
        a_i = 6'd4;
        b_i = 13'd9;
        p_i = 2'd2;
        meas_now(len, hi, ord);
        chk("R6 current period kept length", len, 5);
        chk("R6 current period kept pattern", hi, 2);
        meas_now(len, hi, ord);
        chk("R6 new length after boundary", len, 9);
        chk("R6 new pattern after boundary", hi, 4);
        chk("R6 new code after boundary", int'(psel_o), 2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule